// File: doc/BRIEF.md
# Memory-Mapped BCD Calendar Clock

This block is a byte-wide memory with a running calendar clock in its top eight addresses. A single synchronous request port, with one address, a write enable and a data byte, reaches both the ordinary locations and the clock locations. Reads return their byte on `rdata_o` one clock edge after the request. A one-cycle pulse on `tick_i`, arriving once per second, advances a hidden BCD counter chain. The chain holds seconds, minutes, hours in 24-hour form, day of week, date, month and a two-digit year. Months get their correct length automatically, including leap Februaries.

Seven visible clock bytes are ordinary storage cells. On each tick they are overwritten with the new counter value. A control byte can suspend this copy so that software reads a coherent snapshot while the counters keep running. The control byte can also open the clock for setting. In that case, clearing the set bit loads the seven visible bytes into the counters. The low six bits of the control byte hold a calibration value, which is only stored.

The address space is 19 bits wide. Ordinary locations are served by a backing store of 2^STORE_AW bytes, indexed by the low address bits, so larger addresses alias onto it.

Top module: `bcd_calendar_mem`

## Requirements
- R1: After reset the control byte reads 00h and the clock bytes read 00 s, 00 min, 00 h, weekday 01, date 01, month 01 and year 00, all in BCD. `rdata_o` is 00h.
- R2: A request with `we_i` low places the addressed byte on `rdata_o` at the next clock edge. `rdata_o` then holds until the next read. Addresses below 7FFF8h write and read a backing store indexed by address bits [STORE_AW-1:0].
- R3: Address 7FFF8h is the control byte. Addresses 7FFF9h to 7FFFFh hold, in BCD, seconds, minutes, hours, weekday, date, month and year, in that order of increasing address.
- R4: With control bits 7 and 6 both 0, a tick advances the counters and writes the new time into the seven clock bytes on the same edge. Seconds roll 59→00 into minutes, and minutes roll 59→00 into hours. Hours roll 23→00, which advances the weekday (07→01) and the date.
- R5: The date rolls to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months. In month 02 it rolls after 29 when the year is a multiple of 4 (year 00 included) and after 28 otherwise. A date rollover advances the month. Month 12 rolls to 01 and advances the year, and year 99 rolls to 00.
- R6: While control bit 6 is 1, ticks do not update the clock bytes, but the counters keep advancing. Once the bit is cleared, the next tick shows every second that elapsed.
- R7: While control bit 7 is 1, ticks do not update the clock bytes. A control write with bit 7 = 0 while bit 7 is 1 loads the seven clock bytes into the counters on that edge. A tick in the same cycle as that load is discarded.
- R8: Control bits 5:0 are stored and read back unchanged and have no effect on timekeeping.
- R9: Clock bytes are writable memory cells at any time. A written value reads back until the next copy replaces it, and the counters are not affected by such a write. When a copy and a write to a clock byte fall on the same edge, the copy wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse, once per second |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W (19) | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, registered |

## Verification
Read data is due one edge after the request cycle. A tick changes the clock bytes on the edge that ends the tick cycle, so a read issued in the following cycle already sees the new time. A read issued in the same cycle as the tick returns the old time. A control write that ends a set phase changes the counters on its own edge, and that change becomes visible only through the next copy. The bench drives inputs at the falling edge and advances its behavioural model at the rising edge. It compares `rdata_o` against the model at every following falling edge, so each result is checked in the exact cycle it is due.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NFIELD = 7;
  localparam int unsigned SLOT_W = 3;
  localparam int unsigned F_SEC  = 0;
  localparam int unsigned F_MIN  = 1;
  localparam int unsigned F_HR   = 2;
  localparam int unsigned F_DOW  = 3;
  localparam int unsigned F_DATE = 4;
  localparam int unsigned F_MON  = 5;
  localparam int unsigned F_YR   = 6;
  localparam int unsigned CTL_RD_HOLD = 6;
  localparam int unsigned CTL_WR_OPEN = 7;

  typedef logic [NFIELD-1:0][BYTE_W-1:0] cal_t;

  // year 00, month 01, date 01, weekday 01, 00:00:00
  localparam cal_t CAL_RESET = {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // multiple of 4: even tens need units 0/4/8, odd tens need units 2/6
  function automatic logic leap_year(input logic [7:0] y);
    if (!y[4]) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02:                      return leap_year(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/bcd_cal_counter.sv
module bcd_cal_counter
  import bcd_cal_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic load_i,
  input  cal_t load_val_i,
  output cal_t cnt_o,
  output cal_t nxt_o
);
  cal_t cnt_q;
  cal_t nxt;
  cal_t top_v;
  cal_t low_v;
  logic [NFIELD-1:0] wrap;
  logic [NFIELD-1:0] cin;

  always_comb begin
    top_v         = '0;
    low_v         = '0;
    top_v[F_SEC]  = 8'h59;
    top_v[F_MIN]  = 8'h59;
    top_v[F_HR]   = 8'h23;
    top_v[F_DOW]  = 8'h07;
    top_v[F_DATE] = month_last(cnt_q[F_MON], cnt_q[F_YR]);
    top_v[F_MON]  = 8'h12;
    top_v[F_YR]   = 8'h99;
    low_v[F_DOW]  = 8'h01;
    low_v[F_DATE] = 8'h01;
    low_v[F_MON]  = 8'h01;
  end

  // carry chain: weekday and date both advance on the hour rollover
  assign cin[F_SEC]  = 1'b1;
  assign cin[F_MIN]  = cin[F_SEC]  & wrap[F_SEC];
  assign cin[F_HR]   = cin[F_MIN]  & wrap[F_MIN];
  assign cin[F_DOW]  = cin[F_HR]   & wrap[F_HR];
  assign cin[F_DATE] = cin[F_HR]   & wrap[F_HR];
  assign cin[F_MON]  = cin[F_DATE] & wrap[F_DATE];
  assign cin[F_YR]   = cin[F_MON]  & wrap[F_MON];

  for (genvar i = 0; i < NFIELD; i++) begin : g_field
    assign wrap[i] = (cnt_q[i] == top_v[i]);
    assign nxt[i]  = !cin[i] ? cnt_q[i] : (wrap[i] ? low_v[i] : bcd_inc(cnt_q[i]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= CAL_RESET;
    else if (load_i)  cnt_q <= load_val_i;
    else if (tick_i)  cnt_q <= nxt;
  end

  assign cnt_o = cnt_q;
  assign nxt_o = nxt;
endmodule

// File: rtl/bcd_cal_regs.sv
module bcd_cal_regs
  import bcd_cal_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              tick_i,
  input  cal_t              nxt_i,
  output logic [BYTE_W-1:0] ctrl_o,
  output cal_t              vis_o,
  output logic              load_o
);
  logic [BYTE_W-1:0] ctrl_q;
  cal_t vis_q;
  logic copy;

  assign copy   = tick_i & ~ctrl_q[CTL_WR_OPEN] & ~ctrl_q[CTL_RD_HOLD];
  assign load_o = wr_i & (slot_i == '0) & ctrl_q[CTL_WR_OPEN] & ~wdata_i[CTL_WR_OPEN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     ctrl_q <= '0;
    else if (wr_i && slot_i == '0)   ctrl_q <= wdata_i;
  end

  for (genvar i = 0; i < NFIELD; i++) begin : g_vis
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 vis_q[i] <= CAL_RESET[i];
      else if (copy)                               vis_q[i] <= nxt_i[i];
      else if (wr_i && slot_i == SLOT_W'(i + 1))   vis_q[i] <= wdata_i;
    end
  end

  assign ctrl_o = ctrl_q;
  assign vis_o  = vis_q;
endmodule

// File: rtl/bcd_cal_store.sv
module bcd_cal_store #(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] idx_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 2 ** AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[idx_i] <= wdata_i;
  end

  assign rdata_o = mem[idx_i];
endmodule

// File: rtl/bcd_calendar_mem.sv
module bcd_calendar_mem
  import bcd_cal_pkg::*;
#(
  parameter int unsigned ADDR_W   = 19,
  parameter int unsigned STORE_AW = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o
);
  logic              in_clk;
  logic [SLOT_W-1:0] slot;
  logic              clk_wr;
  logic              store_we;
  logic [BYTE_W-1:0] store_rd;
  logic [BYTE_W-1:0] clk_byte;
  logic [BYTE_W-1:0] ctrl_q;
  cal_t              vis_q;
  cal_t              cnt_q;
  cal_t              cnt_nxt;
  logic              load;
  logic [BYTE_W-1:0] rdata_q;

  assign in_clk   = &addr_i[ADDR_W-1:SLOT_W];
  assign slot     = addr_i[SLOT_W-1:0];
  assign clk_wr   = req_i & we_i & in_clk;
  assign store_we = req_i & we_i & ~in_clk;

  bcd_cal_store #(.AW(STORE_AW), .DW(BYTE_W)) u_store (
    .clk_i   (clk_i),
    .we_i    (store_we),
    .idx_i   (addr_i[STORE_AW-1:0]),
    .wdata_i (wdata_i),
    .rdata_o (store_rd)
  );

  bcd_cal_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (clk_wr),
    .slot_i  (slot),
    .wdata_i (wdata_i),
    .tick_i  (tick_i),
    .nxt_i   (cnt_nxt),
    .ctrl_o  (ctrl_q),
    .vis_o   (vis_q),
    .load_o  (load)
  );

  bcd_cal_counter u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .load_i     (load),
    .load_val_i (vis_q),
    .cnt_o      (cnt_q),
    .nxt_o      (cnt_nxt)
  );

  always_comb begin
    clk_byte = ctrl_q;
    for (int i = 0; i < NFIELD; i++) begin
      if (slot == SLOT_W'(i + 1)) clk_byte = vis_q[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            rdata_q <= '0;
    else if (req_i && !we_i) rdata_q <= in_clk ? clk_byte : store_rd;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/bcd_calendar_mem_chk.sv
module bcd_calendar_mem_chk
  import bcd_cal_pkg::*;
#(
  parameter int unsigned ADDR_W = 19
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [BYTE_W-1:0] rdata_o,
  input logic [BYTE_W-1:0] ctrl_q,
  input cal_t              vis_q,
  input cal_t              cnt_q,
  input logic              load
);
  logic clk_wr;
  logic ctrl_wr;

  assign clk_wr  = req_i && we_i && (&addr_i[ADDR_W-1:SLOT_W]);
  assign ctrl_wr = clk_wr && (addr_i[SLOT_W-1:0] == '0);

  assert_read_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o));

  assert_copy_match_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !ctrl_q[CTL_WR_OPEN] && !ctrl_q[CTL_RD_HOLD]) |=> (vis_q == cnt_q));

  assert_count_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load) |=> $stable(cnt_q));

  assert_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ctrl_q[CTL_RD_HOLD] || ctrl_q[CTL_WR_OPEN]) && !clk_wr) |=> $stable(vis_q));

  assert_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> (cnt_q == $past(vis_q)));

  assert_ctrl_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_wr |=> $stable(ctrl_q));
endmodule

bind bcd_calendar_mem bcd_calendar_mem_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .rdata_o (rdata_o),
  .ctrl_q  (ctrl_q),
  .vis_q   (vis_q),
  .cnt_q   (cnt_q),
  .load    (load)
);

// File: tb/bcd_calendar_mem_bench.sv
module bcd_calendar_mem_bench;
  localparam int AW = 19;
  localparam int SMASK = 1023;
  localparam logic [18:0] A_CTL = 19'h7FFF8;
  localparam logic [18:0] A_SEC = 19'h7FFF9;
  localparam logic [18:0] A_MIN = 19'h7FFFA;
  localparam logic [18:0] A_HR  = 19'h7FFFB;
  localparam logic [18:0] A_DOW = 19'h7FFFC;
  localparam logic [18:0] A_DAT = 19'h7FFFD;
  localparam logic [18:0] A_MON = 19'h7FFFE;
  localparam logic [18:0] A_YR  = 19'h7FFFF;

  logic clk = 0;
  logic rst_n = 0;
  logic tick = 0, req = 0, we = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wd = '0;
  logic [7:0] rdata;

  bcd_calendar_mem u_bcd_calendar_mem (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wd), .rdata_o(rdata)
  );

  always #5 clk = ~clk;

  int vectors = 0, fails = 0, cycles = 0;
  string cur_req = "R1";

  // behavioural model: decimal counters, byte cells
  int t_s, t_mi, t_h, t_dw, t_dt, t_mo, t_y;
  logic [7:0] m_vis [7];
  logic [7:0] m_ctrl, m_rd;
  logic [7:0] m_mem [int];

  function automatic logic [7:0] bcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction
  function automatic int dec(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic int mlen(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_s = 0; t_mi = 0; t_h = 0; t_dw = 1; t_dt = 1; t_mo = 1; t_y = 0;
      m_vis = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};
      m_ctrl = 8'h00; m_rd = 8'h00;
    end else begin
      int n_s, n_mi, n_h, n_dw, n_dt, n_mo, n_y;
      logic [7:0] oc;
      logic inclk, ld;
      int slot;
      oc = m_ctrl;
      inclk = (addr >= A_CTL);
      slot = int'(addr[2:0]);
      ld = req && we && addr == A_CTL && oc[7] && !wd[7];
      n_s = t_s + 1; n_mi = t_mi; n_h = t_h; n_dw = t_dw; n_dt = t_dt; n_mo = t_mo; n_y = t_y;
      if (n_s == 60) begin
        n_s = 0; n_mi++;
        if (n_mi == 60) begin
          n_mi = 0; n_h++;
          if (n_h == 24) begin
            n_h = 0; n_dw = (t_dw == 7) ? 1 : t_dw + 1; n_dt++;
            if (n_dt > mlen(t_mo, t_y)) begin
              n_dt = 1; n_mo++;
              if (n_mo == 13) begin n_mo = 1; n_y = (t_y + 1) % 100; end
            end
          end
        end
      end
      if (req && !we)
        m_rd = inclk ? ((slot == 0) ? m_ctrl : m_vis[slot-1]) : m_mem[int'(addr) & SMASK];
      if (ld) begin
        t_s = dec(m_vis[0]); t_mi = dec(m_vis[1]); t_h = dec(m_vis[2]); t_dw = dec(m_vis[3]);
        t_dt = dec(m_vis[4]); t_mo = dec(m_vis[5]); t_y = dec(m_vis[6]);
      end
      if (req && we) begin
        if (!inclk) m_mem[int'(addr) & SMASK] = wd;
        else if (slot == 0) m_ctrl = wd;
        else m_vis[slot-1] = wd;
      end
      if (tick && !oc[7] && !oc[6])
        m_vis = '{bcd(n_s), bcd(n_mi), bcd(n_h), bcd(n_dw), bcd(n_dt), bcd(n_mo), bcd(n_y)};
      if (!ld && tick) begin
        t_s = n_s; t_mi = n_mi; t_h = n_h; t_dw = n_dw; t_dt = n_dt; t_mo = n_mo; t_y = n_y;
      end
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: cycles=%0d expected <= 100000", cycles);
      summary();
    end
  end

  task automatic cyc(logic r, logic w, logic [AW-1:0] a, logic [7:0] d, logic t);
    @(negedge clk);
    vectors++;
    if (rdata !== m_rd) begin
      fails++;
      $display("FAIL %s: rdata_o=%02h expected %02h (cycle %0d)", cur_req, rdata, m_rd, cycles);
    end
    req = r; we = w; addr = a; wd = d; tick = t;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [7:0] d); cyc(1, 1, a, d, 0); endtask
  task automatic rd(logic [AW-1:0] a); cyc(1, 0, a, 8'h00, 0); endtask
  task automatic tk(); cyc(0, 0, '0, 8'h00, 1); endtask
  task automatic idle(); cyc(0, 0, '0, 8'h00, 0); endtask

  task automatic read_all();
    for (int i = 0; i < 8; i++) rd(A_CTL + 19'(i));
    idle();
  endtask

  task automatic set_time(logic [7:0] s, mi, h, dw, dt, mo, y);
    wr(A_CTL, 8'h80);
    wr(A_SEC, s); wr(A_MIN, mi); wr(A_HR, h); wr(A_DOW, dw);
    wr(A_DAT, dt); wr(A_MON, mo); wr(A_YR, y);
    wr(A_CTL, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R1"; read_all();

    cur_req = "R2";
    wr(19'h00000, 8'hA5); wr(19'h003FF, 8'h3C); wr(19'h7FFF7, 8'h77);
    rd(19'h00000); idle(); idle(); rd(19'h003FF); rd(19'h7FFF7); idle();
    wr(19'h00400, 8'h5A); rd(19'h00000); idle();
    cyc(1, 0, A_SEC, 8'h00, 1); rd(A_SEC); idle();

    cur_req = "R3";
    set_time(8'h45, 8'h34, 8'h12, 8'h03, 8'h15, 8'h06, 8'h21);
    read_all(); tk(); read_all();

    cur_req = "R4";
    set_time(8'h58, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h23);
    tk(); read_all(); tk(); read_all();
    for (int i = 0; i < 70; i++) tk();
    read_all();

    cur_req = "R5";
    set_time(8'h59, 8'h59, 8'h23, 8'h04, 8'h28, 8'h02, 8'h24); tk(); read_all();
    set_time(8'h59, 8'h59, 8'h23, 8'h04, 8'h29, 8'h02, 8'h24); tk(); read_all();
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h00); tk(); read_all();
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h10); tk(); read_all();
    set_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h30, 8'h07, 8'h10); tk(); read_all();
    set_time(8'h59, 8'h59, 8'h23, 8'h06, 8'h31, 8'h12, 8'h99); tk(); read_all();
    set_time(8'h59, 8'h59, 8'h23, 8'h06, 8'h31, 8'h01, 8'h50); tk(); read_all();

    cur_req = "R6";
    wr(A_CTL, 8'h40);
    for (int i = 0; i < 5; i++) tk();
    read_all(); wr(A_CTL, 8'h00); read_all(); tk(); read_all();

    cur_req = "R7";
    wr(A_CTL, 8'h80); tk(); tk(); read_all();
    wr(A_SEC, 8'h10); wr(A_MIN, 8'h20); rd(A_SEC); idle();
    cyc(1, 1, A_CTL, 8'h00, 1);
    read_all(); tk(); read_all();

    cur_req = "R8";
    wr(A_CTL, 8'h2A); rd(A_CTL); tk(); read_all();
    wr(A_CTL, 8'h15); rd(A_CTL); tk(); read_all();
    wr(A_CTL, 8'h00);

    cur_req = "R9";
    wr(A_MIN, 8'h07); rd(A_MIN); tk(); rd(A_MIN); idle();
    cyc(1, 1, A_SEC, 8'h33, 1); rd(A_SEC); read_all();

    idle(); idle();
    summary();
  end
endmodule